// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns queued characters into asynchronous serial frames on a single output line. Characters enter a 16-entry first-in first-out queue through a write strobe. A frame engine takes them out one at a time and sends each one as a low start bit, a payload and a high stop period. Each bit is timed in ticks of a 16x oversampling enable, which comes from an external baud generator.

The payload shape depends on a 3-bit format code. The code selects seven data bits plus parity, eight data bits, eight data bits plus parity, nine data bits, or eight data bits plus a wake-up bit. The parity sense can be odd or even. The stop period can be half a bit, one bit, one and a half bits or two bits long. When flow control is enabled, a new frame waits for the clear-to-send input. A frame that has already started always runs to its end. The queue state is reported on four flag outputs.

The block sits behind a register decoder. The decoder drives the format inputs, the write strobe and the queue-clear pulse. The receive path is not part of this block.

Top module: `sertx_top`

## Requirements
- R1: After reset the line is high, `tx_empty` and `fifo_half_empty` are 1, and `fifo_not_empty` and `fifo_full` are 0.
- R2: A frame begins with a low start bit, and its payload goes out least significant bit first. The start bit and each payload bit last exactly 16 ticks.
- R3: The format code selects the payload. 001 sends `wr_data[7:0]`. 011 sends `wr_data[6:0]` followed by a parity bit. 100 sends `wr_data[8:0]`. 101 sends `wr_data[7:0]` followed by `wr_data[8]` as the wake-up bit. 111 sends `wr_data[7:0]` followed by a parity bit. Any other code behaves as 001.
- R4: The parity bit comes right after the data bits. With `odd_par` = 0 it makes the count of ones over data plus parity even. With `odd_par` = 1 it makes that count odd.
- R5: The stop code gives the length of the high stop period: 00 is 8 ticks, 01 is 16, 10 is 24 and 11 is 32.
- R6: If the queue holds a character and sending is allowed when a stop period ends, the next start bit begins on that same tick, with no idle gap.
- R7: The format code, parity sense and stop code are captured when a frame starts. Changing them while the frame is being sent does not alter that frame.
- R8: With `cts_en` = 1 and `cts` = 0, no new frame starts. Dropping `cts` during a frame does not stop that frame. With `cts_en` = 0, the `cts` input has no effect.
- R9: The queue holds 16 characters, and a write while it is full is discarded. `fifo_half_empty` is 1 when the queue holds 8 or fewer entries. `fifo_not_empty` is 1 when it holds at least one. `fifo_full` is 1 when it holds 16.
- R10: A `fifo_clr` pulse empties the queue from the next cycle. It wins over a write in the same cycle, and the frame in progress still completes.
- R11: `tx_empty` is 1 only when the queue is empty and no frame, including its stop period, is being sent.
- R12: Frames start only on a tick cycle, and the line never changes in a cycle that follows a cycle with no tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | One-cycle 16x oversampling enable from the baud generator |
| mode | input | 3 | Frame format code |
| stop_len | input | 2 | Stop period code |
| odd_par | input | 1 | 1 selects odd parity, 0 selects even parity |
| cts_en | input | 1 | Enables flow-control gating of frame starts |
| cts | input | 1 | Clear-to-send from the peer, active high |
| wr_en | input | 1 | Write strobe into the queue |
| wr_data | input | 9 | Character to queue |
| fifo_clr | input | 1 | Empties the queue |
| txd | output | 1 | Serial line, idles high |
| tx_empty | output | 1 | Queue empty and no frame in progress |
| fifo_half_empty | output | 1 | Queue holds half its depth or less |
| fifo_not_empty | output | 1 | Queue holds at least one character |
| fifo_full | output | 1 | Queue is full |

## Verification
The stimulus targets the tick where one stop period ends and the next start bit begins. A design that idles there for one extra tick stretches every back-to-back frame, and one that starts early cuts the stop period short. Each stop code is driven, including the half-bit one, because an off-by-one in the tick count shows up first in the shortest period. The format code, stop code and parity sense are changed while a frame is on the line, which exposes a design that reads them live instead of capturing them at the start. The queue is filled past capacity, and a clear arrives together with a write in the middle of a frame. These cases catch a queue that wraps and overwrites data, a write that survives a clear, or a clear that cuts off the character already being sent.

// File: rtl/sertx_pkg.sv
// Package: shared widths, format codes and the payload builder for the
// serial frame transmitter. Assumes a 9-bit character word.
package sertx_pkg;

    localparam int CHAR_W = 9;   // width of a queued character
    localparam int PAY_W  = 9;   // longest payload after the start bit
    localparam int NB_W   = 4;   // width of a payload bit count

    localparam logic [2:0] FMT_D8   = 3'b001;
    localparam logic [2:0] FMT_D7P  = 3'b011;
    localparam logic [2:0] FMT_D9   = 3'b100;
    localparam logic [2:0] FMT_D8WK = 3'b101;
    localparam logic [2:0] FMT_D8P  = 3'b111;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_STOP  = 2'd2
    } phase_t;

    typedef struct packed {
        logic [PAY_W-1:0] bits;   // payload, LSB goes out first
        logic [NB_W-1:0]  nbits;  // number of payload bits
    } payload_t;

    // Builds the payload that follows the start bit for one character.
    function automatic payload_t build_payload(input logic [2:0] fmt,
                                               input logic odd,
                                               input logic [CHAR_W-1:0] ch);
        payload_t p;
        case (fmt)
            FMT_D7P: begin
                p.bits  = {1'b0, (^ch[6:0]) ^ odd, ch[6:0]};
                p.nbits = NB_W'(8);
            end
            FMT_D8P: begin
                p.bits  = {(^ch[7:0]) ^ odd, ch[7:0]};
                p.nbits = NB_W'(9);
            end
            FMT_D9, FMT_D8WK: begin
                p.bits  = ch;
                p.nbits = NB_W'(9);
            end
            default: begin
                p.bits  = {1'b0, ch[7:0]};
                p.nbits = NB_W'(8);
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
// Module: character queue for the transmitter.
// A circular buffer with read/write pointers and an occupancy count.
// Assumes DEPTH is a power of two. A clear wins over a write in the same
// cycle, and a write while full is dropped. A read is only issued by the
// frame engine when the queue is non-empty.
module sertx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         half_empty,
    output logic         not_empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          wr_ok, rd_ok;

    // Accept/pop decisions from the count held at the start of the cycle.
    always_comb begin
        wr_ok = wr && !clr && (cnt < CW'(DEPTH));
        rd_ok = rd && !clr && (cnt != '0);
    end

    // Storage write; no reset is needed on the data array.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_ok) wp <= wp + PW'(1);
            if (rd_ok) rp <= rp + PW'(1);
            cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    // Head element and occupancy flags.
    always_comb begin
        rdata      = mem[rp];
        half_empty = (cnt <= CW'(DEPTH / 2));
        not_empty  = (cnt != '0);
        full       = (cnt == CW'(DEPTH));
    end
endmodule

// File: rtl/sertx_framer.sv
// Module: frame engine. Captures the format and the head character when a
// frame starts, then drives start bit, payload and stop period, counting
// oversampling ticks. A frame starts only on a tick, when a character is
// available, flow control allows it and no clear is pending. A start is
// allowed from idle or on the tick that ends a stop period.
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int TPB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              avail,
    input  logic              clr,
    input  logic              cts_en,
    input  logic              cts,
    input  logic [2:0]        fmt,
    input  logic [1:0]        stop_code,
    input  logic              odd,
    input  logic [CHAR_W-1:0] head,
    output logic              pop,
    output logic              txd,
    output logic              busy
);
    localparam int HALF = TPB / 2;
    localparam int CW   = $clog2(2 * TPB) + 1;

    phase_t           ph;
    logic [CW-1:0]    tcnt;
    logic [CW-1:0]    stop_q;
    logic [CW-1:0]    stop_now;
    logic [NB_W-1:0]  left;
    logic [PAY_W-1:0] sh;
    logic             txd_q;
    logic             may_go;
    logic             stop_end;
    payload_t         pay;

    // Start conditions, stop length for a new frame, and payload build.
    always_comb begin
        may_go   = tick && avail && !clr && (!cts_en || cts);
        stop_end = (ph == PH_STOP) && (tcnt == stop_q - CW'(1));
        pop      = may_go && ((ph == PH_IDLE) || stop_end);
        stop_now = CW'((32'(stop_code) + 32'd1) * HALF);
        pay      = build_payload(fmt, odd, head);
    end

    // Bit sequencing, advanced only on tick cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= PH_IDLE;
            txd_q  <= 1'b1;
            tcnt   <= '0;
            stop_q <= '0;
            left   <= '0;
            sh     <= '0;
        end else if (pop) begin
            ph     <= PH_SHIFT;
            txd_q  <= 1'b0;
            tcnt   <= '0;
            stop_q <= stop_now;
            left   <= pay.nbits;
            sh     <= pay.bits;
        end else if (tick) begin
            case (ph)
                PH_SHIFT: begin
                    if (tcnt == CW'(TPB - 1)) begin
                        tcnt <= '0;
                        if (left != '0) begin
                            txd_q <= sh[0];
                            sh    <= sh >> 1;
                            left  <= left - NB_W'(1);
                        end else begin
                            txd_q <= 1'b1;
                            ph    <= PH_STOP;
                        end
                    end else begin
                        tcnt <= tcnt + CW'(1);
                    end
                end
                PH_STOP: begin
                    if (stop_end) begin
                        ph   <= PH_IDLE;
                        tcnt <= '0;
                    end else begin
                        tcnt <= tcnt + CW'(1);
                    end
                end
                default: txd_q <= 1'b1;
            endcase
        end
    end

    // Registered line and activity outputs.
    always_comb begin
        txd  = txd_q;
        busy = (ph != PH_IDLE);
    end
endmodule

// File: rtl/sertx_top.sv
// Module: asynchronous serial frame transmitter top. Connects the queue
// and the frame engine and derives the transmitter-empty flag.
// Assumes tick16 is a one-cycle enable at 16x the bit rate.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int FIFO_DEPTH    = 16,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic [2:0]        mode,
    input  logic [1:0]        stop_len,
    input  logic              odd_par,
    input  logic              cts_en,
    input  logic              cts,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              fifo_clr,
    output logic              txd,
    output logic              tx_empty,
    output logic              fifo_half_empty,
    output logic              fifo_not_empty,
    output logic              fifo_full
);
    logic              pop;
    logic              busy;
    logic [CHAR_W-1:0] head;

    sertx_fifo #(.DEPTH(FIFO_DEPTH), .W(CHAR_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .wr         (wr_en),
        .wdata      (wr_data),
        .rd         (pop),
        .rdata      (head),
        .half_empty (fifo_half_empty),
        .not_empty  (fifo_not_empty),
        .full       (fifo_full)
    );

    sertx_framer #(.TPB(TICKS_PER_BIT)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .avail     (fifo_not_empty),
        .clr       (fifo_clr),
        .cts_en    (cts_en),
        .cts       (cts),
        .fmt       (mode),
        .stop_code (stop_len),
        .odd       (odd_par),
        .head      (head),
        .pop       (pop),
        .txd       (txd),
        .busy      (busy)
    );

    // Empty only when nothing is queued and the engine is idle.
    always_comb tx_empty = !busy && !fifo_not_empty;
endmodule

// File: rtl/sertx_chk.sv
// Module: property checker for sertx_top, attached with bind below.
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick16,
    input logic cts_en,
    input logic cts,
    input logic fifo_clr,
    input logic pop,
    input logic txd,
    input logic tx_empty,
    input logic fifo_half_empty,
    input logic fifo_not_empty,
    input logic fifo_full
);
    logic seen;

    // Marks that at least one clock has passed out of reset.
    always_ff @(posedge clk) seen <= rst_n;

    assert_line_high_when_empty_R11: assert property (@(posedge clk)
        disable iff (!rst_n) tx_empty |-> txd);

    assert_empty_implies_queue_empty_R11: assert property (@(posedge clk)
        disable iff (!rst_n) tx_empty |-> !fifo_not_empty);

    assert_full_flags_agree_R9: assert property (@(posedge clk)
        disable iff (!rst_n) fifo_full |-> (fifo_not_empty && !fifo_half_empty));

    assert_clear_empties_R10: assert property (@(posedge clk)
        disable iff (!rst_n || !seen) fifo_clr |=> !fifo_not_empty);

    assert_cts_blocks_start_R8: assert property (@(posedge clk)
        disable iff (!rst_n) pop |-> (!cts_en || cts));

    assert_start_on_tick_R12: assert property (@(posedge clk)
        disable iff (!rst_n) pop |-> tick16);

    assert_line_still_without_tick_R12: assert property (@(posedge clk)
        disable iff (!rst_n || !seen) !tick16 |=> $stable(txd));
endmodule

bind sertx_top sertx_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick16          (tick16),
    .cts_en          (cts_en),
    .cts             (cts),
    .fifo_clr        (fifo_clr),
    .pop             (pop),
    .txd             (txd),
    .tx_empty        (tx_empty),
    .fifo_half_empty (fifo_half_empty),
    .fifo_not_empty  (fifo_not_empty),
    .fifo_full       (fifo_full)
);

// File: tb/sertx_top_bench.sv
`timescale 1ns/1ps
module sertx_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic [2:0] mode = 3'b001;
    logic [1:0] stop_len = 2'b01;
    logic       odd_par = 1'b0;
    logic       cts_en = 1'b0;
    logic       cts = 1'b1;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       fifo_clr = 1'b0;
    logic       txd, tx_empty, fifo_half_empty, fifo_not_empty, fifo_full;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R2";
    bit    cmp_on = 1'b0;
    bit    tick_run = 1'b1;
    int    tick_div = 3;
    int    tick_cnt = 0;

    always #2.5 clk = ~clk;

    sertx_top u_sertx_top (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .mode(mode),
        .stop_len(stop_len), .odd_par(odd_par), .cts_en(cts_en), .cts(cts),
        .wr_en(wr_en), .wr_data(wr_data), .fifo_clr(fifo_clr), .txd(txd),
        .tx_empty(tx_empty), .fifo_half_empty(fifo_half_empty),
        .fifo_not_empty(fifo_not_empty), .fifo_full(fifo_full)
    );

    // Tick source.
    always @(negedge clk) begin
        if (tick_run && tick_cnt >= tick_div - 1) begin
            tick16 = 1'b1;
            tick_cnt = 0;
        end else begin
            tick16 = 1'b0;
            if (tick_run) tick_cnt = tick_cnt + 1;
        end
    end

    // Reference model: queue of characters and a queue of line levels, one per tick.
    logic [8:0] mq[$];
    int         lv[$];
    int         m_sz0;
    bit         m_go;

    function automatic void m_launch(logic [8:0] c);
        int nd, ones, extra;
        bit has_x;
        nd = 8; has_x = 0; extra = 0;
        case (mode)
            3'b011: begin nd = 7; has_x = 1; end
            3'b111: begin nd = 8; has_x = 1; end
            3'b100: begin nd = 9; end
            3'b101: begin nd = 8; has_x = 1; end
            default: nd = 8;
        endcase
        ones = 0;
        for (int i = 0; i < nd; i++) ones += int'(c[i]);
        if (mode == 3'b101) extra = int'(c[8]);
        else extra = (ones % 2) ^ int'(odd_par);
        for (int k = 0; k < 16; k++) lv.push_back(0);
        for (int i = 0; i < nd; i++)
            for (int k = 0; k < 16; k++) lv.push_back(int'(c[i]));
        if (has_x)
            for (int k = 0; k < 16; k++) lv.push_back(extra);
        for (int k = 0; k < (int'(stop_len) + 1) * 8; k++) lv.push_back(1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            lv.delete();
        end else begin
            m_sz0 = mq.size();
            if (tick16 && lv.size() > 0) void'(lv.pop_front());
            m_go = tick16 && lv.size() == 0 && m_sz0 > 0 && (!cts_en || cts) && !fifo_clr;
            if (m_go) m_launch(mq.pop_front());
            if (fifo_clr) mq.delete();
            else if (wr_en && m_sz0 < 16) mq.push_back(wr_data);
        end
    end

    function automatic void note(bit ok, string tag, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endfunction

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            int e_txd, e_emp, e_half, e_ne, e_full;
            e_txd  = (lv.size() > 0) ? lv[0] : 1;
            e_emp  = (lv.size() == 0 && mq.size() == 0) ? 1 : 0;
            e_half = (mq.size() <= 8) ? 1 : 0;
            e_ne   = (mq.size() > 0) ? 1 : 0;
            e_full = (mq.size() == 16) ? 1 : 0;
            note(int'(txd) == e_txd, {cur_req, " txd"}, int'(txd), e_txd);
            note(int'(tx_empty) == e_emp, "R11 tx_empty", int'(tx_empty), e_emp);
            note(int'(fifo_half_empty) == e_half, "R9 half_empty", int'(fifo_half_empty), e_half);
            note(int'(fifo_not_empty) == e_ne, "R9 not_empty", int'(fifo_not_empty), e_ne);
            note(int'(fifo_full) == e_full, "R9 full", int'(fifo_full), e_full);
        end
    end

    task automatic put(logic [8:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!tx_empty && n < 30000) begin @(negedge clk); n++; end
        note(n < 30000, {cur_req, " drain"}, n, 0);
        repeat (8) @(negedge clk);
    endtask

    task automatic one(logic [2:0] m, logic o, logic [1:0] s, logic [8:0] d, string tag);
        cur_req = tag; mode = m; odd_par = o; stop_len = s;
        put(d);
        wait_done();
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic keep;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        note(txd == 1'b1, "R1 txd", int'(txd), 1);
        note(tx_empty == 1'b1, "R1 tx_empty", int'(tx_empty), 1);
        note(fifo_half_empty == 1'b1, "R1 half_empty", int'(fifo_half_empty), 1);
        note(fifo_not_empty == 1'b0, "R1 not_empty", int'(fifo_not_empty), 0);
        note(fifo_full == 1'b0, "R1 full", int'(fifo_full), 0);
        cmp_on = 1'b1;

        // R2 and R6: back-to-back 8-bit frames.
        cur_req = "R6";
        put(9'h0A5); put(9'h03C); put(9'h1FF);
        wait_done();

        // R3 and R4: every format code with both parity senses.
        for (int m = 0; m < 8; m++) begin
            one(3'(m), 1'b0, 2'b01, 9'h153, "R3");
            one(3'(m), 1'b1, 2'b01, 9'h0B6, "R4");
        end

        // R5: every stop length, two frames each so the stop period ends before a start.
        for (int s = 0; s < 4; s++) begin
            cur_req = "R5"; stop_len = 2'(s); mode = 3'b001;
            put(9'h081); put(9'h07E);
            wait_done();
        end

        // R7: change configuration while a frame is on the line.
        cur_req = "R7"; mode = 3'b111; odd_par = 1'b0; stop_len = 2'b11;
        put(9'h0C3);
        repeat (60) @(negedge clk);
        mode = 3'b011; odd_par = 1'b1; stop_len = 2'b00;
        wait_done();

        // R8: flow control.
        cur_req = "R8"; mode = 3'b001; stop_len = 2'b01;
        cts_en = 1'b1; cts = 1'b0;
        put(9'h05A);
        repeat (300) @(negedge clk);
        note(txd == 1'b1, "R8 held idle txd", int'(txd), 1);
        note(fifo_not_empty == 1'b1, "R8 held not_empty", int'(fifo_not_empty), 1);
        cts = 1'b1;
        repeat (80) @(negedge clk);
        cts = 1'b0;
        wait_done();
        cts_en = 1'b0;
        put(9'h0E1);
        wait_done();

        // R9: overfill while blocked.
        cur_req = "R9"; cts_en = 1'b1; cts = 1'b0;
        for (int i = 0; i < 18; i++) put(9'(i * 7 + 3));
        note(fifo_full == 1'b1, "R9 full after overfill", int'(fifo_full), 1);
        note(fifo_half_empty == 1'b0, "R9 half_empty when full", int'(fifo_half_empty), 0);
        cts = 1'b1;
        wait_done();
        cts_en = 1'b0;

        // R10: clear with a simultaneous write, frame in progress finishes.
        cur_req = "R10"; cts_en = 1'b1; cts = 1'b0;
        for (int i = 0; i < 5; i++) put(9'(i + 40));
        fifo_clr = 1'b1; wr_en = 1'b1; wr_data = 9'h1AA;
        @(negedge clk);
        fifo_clr = 1'b0; wr_en = 1'b0;
        note(fifo_not_empty == 1'b0, "R10 cleared", int'(fifo_not_empty), 0);
        cts_en = 1'b0;
        put(9'h066); put(9'h099); put(9'h011);
        repeat (100) @(negedge clk);
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
        note(fifo_not_empty == 1'b0, "R10 cleared mid frame", int'(fifo_not_empty), 0);
        note(tx_empty == 1'b0, "R10 frame still running", int'(tx_empty), 0);
        wait_done();

        // R12: pause the tick source in mid frame.
        cur_req = "R12"; tick_div = 2;
        put(9'h0F0);
        repeat (90) @(negedge clk);
        tick_run = 1'b0;
        @(negedge clk);
        keep = txd;
        repeat (200) @(negedge clk);
        note(txd == keep, "R12 line held", int'(txd), int'(keep));
        tick_run = 1'b1;
        wait_done();

        cmp_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule